// File: doc/BRIEF.md
# Ancillary Data Packet Formatter

This block builds one 10-bit ancillary data packet for a serial digital video word stream. A data count is captured first. When a packet-ready request arrives, the block emits the whole packet as a contiguous run of valid words: a three-word flag, then the identifier, the block number, the count, the user words, and a closing checksum. The identifier and block number values are fixed by parameters.

User words are sampled from the same input bus that carries the count. A take strobe marks each cycle in which the bus is consumed as a user word, so the source can advance its data after each strobe. Each packet selects one of two user-word encodings. In raw mode, a 9-bit payload is sent with its top bit forced high. In parity mode, an 8-bit byte is sent with two parity bits computed from it. The block does not choose where in the video line the packet is placed.

Top module: `ancfmt_top`

## Requirements
- R1: During and after reset, with no request, `empty_o` is 1 and `valid_o` is 0.
- R2: The first three valid words of every packet are 0x000, 0x3FF and 0x3FF, in that order.
- R3: Words 3, 4 and 5 carry the identifier, the block number and the count. Each is an 8-bit value v with bit 8 equal to the XOR of v[7:0] and bit 9 equal to the inverse of bit 8.
- R4: A packet holds exactly count+7 valid words, with no gap between them, for any count from 0 to 255.
- R5: When `parity_mode` is 0, a user word equals {1, din[8:0]} as sampled.
- R6: When `parity_mode` is 1, a user word is built from din[7:0] using the encoding of R3. din[9:8] are ignored.
- R7: The last word is the checksum. Its bits 8:0 are the sum modulo 512 of bits 8:0 of every word from word 3 through the last user word. Its bit 9 is the inverse of bit 8. The flag words are excluded, and the sum restarts with each packet.
- R8: A packet starts at the first clock edge where `pkt_ready` is sampled high while idle. `empty_o` falls at that edge. The first word is valid after the next edge. `empty_o` rises one cycle after the checksum word. `empty_o` is 0 whenever `valid_o` is 1.
- R9: A `dc_load` strobe or a held `pkt_ready` that arrives while a packet is in flight has no effect on that packet.
- R10: `take_o` is 1 in exactly count cycles per packet. The value of `din` at the edge that ends each such cycle becomes the next user word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_load | input | 1 | One-cycle strobe that captures din[7:0] as the data count while idle |
| din | input | 10 | Count on load, user data while take_o is high |
| pkt_ready | input | 1 | Request to start sending the packet |
| parity_mode | input | 1 | 1 selects 8-bit user bytes with computed parity |
| word_o | output | 10 | Packet word |
| valid_o | output | 1 | word_o holds a packet word |
| empty_o | output | 1 | High when no packet is held or being sent |
| take_o | output | 1 | din is consumed as a user word at the coming edge |

## Verification
Packets are sent with counts of 0, 1, 2, 5, 17, 43 and 255, so the empty packet, the single-word packet and the full-size packet each exercise the end condition and the checksum wrap. Raw-mode packets use payloads with random high bits, which separates forced bit 9 from a passed-through bit 9. Parity-mode packets carry junk in din[9:8], which separates computed parity from copied bits. Two packets receive a spurious count load and a prolonged request in mid-flight; a length or checksum mismatch on those packets would show that the in-flight count was disturbed.

// File: rtl/ancfmt_pkg.sv
package ancfmt_pkg;

    localparam int WORD_W = 10;
    localparam int DC_W   = 8;
    localparam int POS_W  = DC_W + 1;
    localparam int SUM_W  = WORD_W - 1;
    localparam int HDR_WORDS = 6;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DC_W-1:0]   count_t;
    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef enum logic [2:0] {
        FLD_FLAG0,
        FLD_FLAG1,
        FLD_ID,
        FLD_BLK,
        FLD_CNT,
        FLD_USER,
        FLD_CSUM
    } field_e;

    // 8-bit value with even parity in bit 8 and its inverse in bit 9
    function automatic word_t tag_byte(input logic [7:0] b);
        logic p;
        p = ^b;
        return {~p, p, b};
    endfunction

    function automatic word_t raw_word(input logic [8:0] v);
        return {1'b1, v};
    endfunction

    function automatic word_t sum_word(input sum_t s);
        return {~s[SUM_W-1], s};
    endfunction

endpackage

// File: rtl/ancfmt_seq.sv
module ancfmt_seq
    import ancfmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dc_load,
    input  count_t dc_in,
    input  logic   pkt_ready,
    output logic   busy_o,
    output logic   start_o,
    output logic   take_o,
    output field_e field_o,
    output count_t dc_o
);

    logic   busy;
    pos_t   pos;
    count_t dc;
    pos_t   last_pos;

    assign last_pos = pos_t'(dc) + pos_t'(HDR_WORDS);
    assign start_o  = !busy && pkt_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pos  <= '0;
            dc   <= '0;
        end else begin
            if (!busy && dc_load)
                dc <= dc_in;
            if (start_o) begin
                busy <= 1'b1;
                pos  <= '0;
            end else if (busy) begin
                if (pos == last_pos)
                    busy <= 1'b0;
                pos <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        case (pos)
            pos_t'(0):         field_o = FLD_FLAG0;
            pos_t'(1),
            pos_t'(2):         field_o = FLD_FLAG1;
            pos_t'(3):         field_o = FLD_ID;
            pos_t'(4):         field_o = FLD_BLK;
            pos_t'(5):         field_o = FLD_CNT;
            default:           field_o = (pos == last_pos) ? FLD_CSUM : FLD_USER;
        endcase
    end

    assign busy_o = busy;
    assign take_o = busy && (field_o == FLD_USER);
    assign dc_o   = dc;

    // R4
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pos <= last_pos));

    // R9
    dc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dc));

endmodule

// File: rtl/ancfmt_word.sv
module ancfmt_word
    import ancfmt_pkg::*;
#(
    parameter logic [7:0] ID_VAL  = 8'h45,
    parameter logic [7:0] BLK_VAL = 8'h01
) (
    input  field_e field_i,
    input  word_t  din,
    input  logic   parity_mode,
    input  count_t dc,
    input  sum_t   sum,
    output word_t  word_o
);

    always_comb begin
        case (field_i)
            FLD_FLAG0: word_o = '0;
            FLD_FLAG1: word_o = '1;
            FLD_ID:    word_o = tag_byte(ID_VAL);
            FLD_BLK:   word_o = tag_byte(BLK_VAL);
            FLD_CNT:   word_o = tag_byte(8'(dc));
            FLD_USER:  word_o = parity_mode ? tag_byte(din[7:0]) : raw_word(din[8:0]);
            FLD_CSUM:  word_o = sum_word(sum);
            default:   word_o = '0;
        endcase
    end

endmodule

// File: rtl/ancfmt_csum.sv
module ancfmt_csum
    import ancfmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic add,
    input  sum_t val,
    output sum_t sum_o
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum_o <= '0;
        else if (add)
            sum_o <= sum_o + val;
    end

    // R7
    csum_excl_chk: assert property (@(posedge clk) disable iff (rst)
        clr |-> !add);

endmodule

// File: rtl/ancfmt_top.sv
module ancfmt_top
    import ancfmt_pkg::*;
#(
    parameter logic [7:0] ID_VAL  = 8'h45,
    parameter logic [7:0] BLK_VAL = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dc_load,
    input  logic [9:0]  din,
    input  logic        pkt_ready,
    input  logic        parity_mode,
    output logic [9:0]  word_o,
    output logic        valid_o,
    output logic        empty_o,
    output logic        take_o
);

    logic   busy, start;
    field_e field;
    count_t dc;
    sum_t   sum;
    word_t  word_next;
    logic   sum_add;

    ancfmt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .dc_load   (dc_load),
        .dc_in     (din[DC_W-1:0]),
        .pkt_ready (pkt_ready),
        .busy_o    (busy),
        .start_o   (start),
        .take_o    (take_o),
        .field_o   (field),
        .dc_o      (dc)
    );

    ancfmt_word #(.ID_VAL(ID_VAL), .BLK_VAL(BLK_VAL)) u_word (
        .field_i     (field),
        .din         (din),
        .parity_mode (parity_mode),
        .dc          (dc),
        .sum         (sum),
        .word_o      (word_next)
    );

    assign sum_add = busy && (field inside {FLD_ID, FLD_BLK, FLD_CNT, FLD_USER});

    ancfmt_csum u_csum (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .add   (sum_add),
        .val   (word_next[SUM_W-1:0]),
        .sum_o (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= busy;
            word_o  <= busy ? word_next : '0;
        end
    end

    assign empty_o = !busy && !valid_o;

    // R2
    flag_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(empty_o) |=> (valid_o && word_o == 10'h000));

    // R8
    empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(empty_o) |-> $past(valid_o));

endmodule

// File: tb/test_ancfmt_top.sv
module test_ancfmt_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ID_V  = 8'h45;
    localparam logic [7:0] BLK_V = 8'h01;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dc_load = 1'b0;
    logic       pkt_ready = 1'b0;
    logic       parity_mode = 1'b0;
    logic [9:0] load_val = '0;
    logic [9:0] udw_val = '0;
    logic [9:0] din;
    logic [9:0] word_o;
    logic       valid_o, empty_o, take_o;

    int tests = 0;
    int fails = 0;
    int seen = 0;
    int uidx = 0;
    logic [9:0] ud [256];
    logic [9:0] exp_q [$];

    assign din = dc_load ? load_val : udw_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    ancfmt_top #(.ID_VAL(ID_V), .BLK_VAL(BLK_V)) i_ancfmt_top (
        .clk(clk), .rst(rst), .dc_load(dc_load), .din(din),
        .pkt_ready(pkt_ready), .parity_mode(parity_mode),
        .word_o(word_o), .valid_o(valid_o), .empty_o(empty_o), .take_o(take_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [9:0] enc8(input logic [7:0] b);
        int ones = 0;
        for (int k = 0; k < 8; k++) if (b[k]) ones++;
        return {(ones % 2 == 0), (ones % 2 == 1), b};
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            seen++;
            check("R8 empty low while valid", {31'd0, empty_o}, 32'd0);
            if (exp_q.size() == 0)
                check("R4 unexpected word", 32'd1, 32'd0);
            else
                check("R2/R3/R5/R6/R7 word", {22'd0, word_o}, {22'd0, exp_q.pop_front()});
        end
    end

    // user data source, advanced on each take strobe (R10)
    always @(negedge clk) begin
        if (!rst && take_o) begin
            udw_val = ud[uidx];
            uidx++;
        end
    end

    task automatic run_pkt(input int n, input bit pm, input bit poke);
        int sum = 0;
        int guard;
        logic [9:0] w;
        for (int i = 0; i < 256; i++)
            ud[i] = 10'((i * 37 + n * 11 + 5) ^ ((i * 7) << 5));
        exp_q.delete();
        exp_q.push_back(10'h000);
        exp_q.push_back(10'h3FF);
        exp_q.push_back(10'h3FF);
        w = enc8(ID_V);  exp_q.push_back(w); sum += w[8:0];
        w = enc8(BLK_V); exp_q.push_back(w); sum += w[8:0];
        w = enc8(8'(n)); exp_q.push_back(w); sum += w[8:0];
        for (int i = 0; i < n; i++) begin
            w = pm ? enc8(ud[i][7:0]) : {1'b1, ud[i][8:0]};
            exp_q.push_back(w);
            sum += w[8:0];
        end
        sum = sum % 512;
        exp_q.push_back({~sum[8], sum[8:0]});

        @(negedge clk);
        load_val = 10'(n) | 10'h300;
        dc_load = 1'b1;
        @(negedge clk);
        dc_load = 1'b0;
        parity_mode = pm;
        seen = 0;
        uidx = 0;
        check("R1/R8 empty before request", {31'd0, empty_o}, 32'd1);
        pkt_ready = 1'b1;
        @(negedge clk);
        check("R8 empty falls at start", {31'd0, empty_o}, 32'd0);
        check("R8 no word yet", {31'd0, valid_o}, 32'd0);
        if (poke) begin
            // R9: stray load and held request mid-packet
            load_val = 10'd3;
            dc_load = 1'b1;
            @(negedge clk);
            dc_load = 1'b0;
            @(negedge clk);
        end
        pkt_ready = 1'b0;
        guard = 0;
        while (!empty_o && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        check("R4/R9 packet length", seen, n + 7);
        check("R7 all words consumed", exp_q.size(), 0);
        check("R10 take count", uidx, n);
        @(negedge clk);
        check("R8 idle after packet", {30'd0, empty_o, valid_o}, 32'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset empty", {31'd0, empty_o}, 32'd1);
        check("R1 reset valid", {31'd0, valid_o}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle empty", {31'd0, empty_o}, 32'd1);
        check("R1 idle valid", {31'd0, valid_o}, 32'd0);
        run_pkt(0, 1'b0, 1'b0);
        run_pkt(5, 1'b1, 1'b0);
        run_pkt(43, 1'b0, 1'b1);
        run_pkt(17, 1'b1, 1'b1);
        run_pkt(255, 1'b0, 1'b0);
        run_pkt(1, 1'b1, 1'b0);
        run_pkt(2, 1'b0, 1'b0);
        run_pkt(255, 1'b1, 1'b0);
        summary();
    end

endmodule